// File: doc/BRIEF.md
# Gate Direction Detector

This block watches two beam-break sensors mounted side by side across one gate lane. Sensor a is the outer beam and sensor b the inner beam. A car passing through blocks and then clears the two beams in an order that shows its direction. A synchronous state machine follows that order and, once a car has completely cleared the gate, emits a single-cycle strobe on `enter_o` for an inbound car or on `exit_o` for an outbound one.

A pattern that stops before it is complete gives no strobe. A person walking through typically blocks only one beam, or breaks the expected order, so it gives no strobe either. An out-of-order combination makes the machine drop the pattern it was following and ignore the sensors until both beams read clear again. The sensor levels are also passed straight through to two indicator outputs, one per sensor. The inputs are assumed to be debounced and synchronised to `clk_i` already.

Top module: `gate_dir_detector`

## Requirements
- R1: An input reads 1 while its beam is blocked and 0 while it is clear. `led_a_o` equals `a_i` and `led_b_o` equals `b_i` in the same cycle, with no register in between.
- R2: The input sequence {a,b} = 00, 10, 11, 01, 00, sampled on consecutive rising edges of `clk_i` and each step held for any number of cycles, raises `enter_o` during the cycle that follows the edge which samples the closing 00.
- R3: The sequence {a,b} = 00, 01, 11, 10, 00 raises `exit_o` with the same timing.
- R4: Each recognised car gives a pulse that is exactly one cycle long. `enter_o` and `exit_o` are never high together.
- R5: Holding any step of a valid sequence for several cycles neither breaks the sequence nor adds pulses.
- R6: If {a,b} returns to 00 before the final step of a sequence (01 for entry, 10 for exit) has been seen, no pulse is produced. The machine is armed again at once, so a sequence that starts on the next sample is recognised.
- R7: A combination that does not follow the current step, such as 11 straight from 00, 01 straight after 10, or a step backwards, produces no pulse. The machine then ignores every input until it samples 00.
- R8: While `rst_i` is high at a rising edge, both strobes are low in the following cycle. After reset the machine waits for a sample of 00 before it accepts the first step of a sequence.
- R9: Cars may follow one another directly. The closing 00 of one sequence also serves as the opening 00 of the next.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| a_i | input | 1 | Outer beam, 1 while blocked |
| b_i | input | 1 | Inner beam, 1 while blocked |
| enter_o | output | 1 | One-cycle strobe for an inbound car |
| exit_o | output | 1 | One-cycle strobe for an outbound car |
| led_a_o | output | 1 | Indicator level for the outer beam |
| led_b_o | output | 1 | Indicator level for the inner beam |

## Verification
The bench targets several corner cases. Sequences that are aborted by an early 00 must not give a pulse; a design that counts on the first clear would give a false count. After an abort the machine must re-arm at once; a design that waits an extra cycle would miss a car that starts straight away. Out-of-order and backward steps must be ignored until both beams clear; a design that re-syncs too early would count a car that half passed. Reset while a beam is already blocked must not count that car, and back-to-back cars sharing one 00 must each be counted; a design that gets either wrong would miscount by one. Long holds on every step check for pulses that are doubled or stretched.

// File: rtl/gdd_pkg.sv
package gdd_pkg;

    // Sensor pair decoded as {a, b}; a is the outer beam.
    typedef enum logic [1:0] {
        BEAM_NONE  = 2'b00,
        BEAM_INNER = 2'b01,
        BEAM_OUTER = 2'b10,
        BEAM_BOTH  = 2'b11
    } beam_t;

    typedef enum logic [2:0] {
        GS_WAIT  = 3'd0,   // discard input until both beams clear
        GS_ARMED = 3'd1,   // both clear, ready for a first step
        GS_IN1   = 3'd2,   // outer only
        GS_IN2   = 3'd3,   // both, inbound
        GS_IN3   = 3'd4,   // inner only, inbound
        GS_OUT1  = 3'd5,   // inner only
        GS_OUT2  = 3'd6,   // both, outbound
        GS_OUT3  = 3'd7    // outer only, outbound
    } gate_state_t;

    typedef struct packed {
        gate_state_t st;
        logic        enter_p;
        logic        exit_p;
    } gdd_regs_t;

endpackage

// File: rtl/gdd_beam_decode.sv
module gdd_beam_decode
    import gdd_pkg::*;
(
    input  logic  a_i,
    input  logic  b_i,
    output beam_t beam_o
);
    always_comb begin
        unique case ({a_i, b_i})
            2'b00:   beam_o = BEAM_NONE;
            2'b01:   beam_o = BEAM_INNER;
            2'b10:   beam_o = BEAM_OUTER;
            default: beam_o = BEAM_BOTH;
        endcase
    end
endmodule

// File: rtl/gdd_step_logic.sv
module gdd_step_logic
    import gdd_pkg::*;
(
    input  gate_state_t cur_i,
    input  beam_t       beam_i,
    output gate_state_t nxt_o,
    output logic        fire_in_o,
    output logic        fire_out_o
);
    // Step of a pass: hold on the same beam, advance on the next one,
    // re-arm on an early clear, otherwise drop to WAIT.
    function automatic gate_state_t follow(input beam_t here, input beam_t ahead,
                                           input gate_state_t self,
                                           input gate_state_t advance,
                                           input beam_t b);
        if (b == here)           return self;
        else if (b == ahead)     return advance;
        else if (b == BEAM_NONE) return GS_ARMED;
        else                     return GS_WAIT;
    endfunction

    always_comb begin
        nxt_o      = cur_i;
        fire_in_o  = 1'b0;
        fire_out_o = 1'b0;
        unique case (cur_i)
            GS_WAIT:  nxt_o = (beam_i == BEAM_NONE) ? GS_ARMED : GS_WAIT;
            GS_ARMED: begin
                unique case (beam_i)
                    BEAM_NONE:  nxt_o = GS_ARMED;
                    BEAM_OUTER: nxt_o = GS_IN1;
                    BEAM_INNER: nxt_o = GS_OUT1;
                    default:    nxt_o = GS_WAIT;
                endcase
            end
            GS_IN1:  nxt_o = follow(BEAM_OUTER, BEAM_BOTH,  GS_IN1,  GS_IN2,  beam_i);
            GS_IN2:  nxt_o = follow(BEAM_BOTH,  BEAM_INNER, GS_IN2,  GS_IN3,  beam_i);
            GS_OUT1: nxt_o = follow(BEAM_INNER, BEAM_BOTH,  GS_OUT1, GS_OUT2, beam_i);
            GS_OUT2: nxt_o = follow(BEAM_BOTH,  BEAM_OUTER, GS_OUT2, GS_OUT3, beam_i);
            GS_IN3: begin
                if (beam_i == BEAM_INNER) nxt_o = GS_IN3;
                else if (beam_i == BEAM_NONE) begin
                    nxt_o     = GS_ARMED;
                    fire_in_o = 1'b1;
                end else nxt_o = GS_WAIT;
            end
            GS_OUT3: begin
                if (beam_i == BEAM_OUTER) nxt_o = GS_OUT3;
                else if (beam_i == BEAM_NONE) begin
                    nxt_o      = GS_ARMED;
                    fire_out_o = 1'b1;
                end else nxt_o = GS_WAIT;
            end
            default: nxt_o = GS_WAIT;
        endcase
    end
endmodule

// File: rtl/gate_dir_detector.sv
module gate_dir_detector
    import gdd_pkg::*;
(
    input  logic clk_i,
    input  logic rst_i,
    input  logic a_i,
    input  logic b_i,
    output logic enter_o,
    output logic exit_o,
    output logic led_a_o,
    output logic led_b_o
);
    beam_t       beam;
    gate_state_t step_nxt;
    logic        fire_in;
    logic        fire_out;
    gdd_regs_t   regs_d;
    gdd_regs_t   regs_q;

    gdd_beam_decode u_decode (
        .a_i    (a_i),
        .b_i    (b_i),
        .beam_o (beam)
    );

    gdd_step_logic u_step (
        .cur_i      (regs_q.st),
        .beam_i     (beam),
        .nxt_o      (step_nxt),
        .fire_in_o  (fire_in),
        .fire_out_o (fire_out)
    );

    always_comb begin
        regs_d         = regs_q;
        regs_d.st      = step_nxt;
        regs_d.enter_p = fire_in;
        regs_d.exit_p  = fire_out;
        if (rst_i) begin
            regs_d.st      = GS_WAIT;
            regs_d.enter_p = 1'b0;
            regs_d.exit_p  = 1'b0;
        end
    end

    always_ff @(posedge clk_i) begin
        regs_q <= regs_d;
    end

    assign enter_o = regs_q.enter_p;
    assign exit_o  = regs_q.exit_p;
    assign led_a_o = a_i;
    assign led_b_o = b_i;
endmodule

// File: rtl/gdd_checker.sv
module gdd_checker (
    input logic clk_i,
    input logic rst_i,
    input logic a_i,
    input logic b_i,
    input logic enter_o,
    input logic exit_o
);
    assert_reset_quiet_R8: assert property (@(posedge clk_i)
        rst_i |=> (!enter_o && !exit_o));

    assert_enter_one_cycle_R4: assert property (@(posedge clk_i) disable iff (rst_i)
        enter_o |=> !enter_o);

    assert_exit_one_cycle_R4: assert property (@(posedge clk_i) disable iff (rst_i)
        exit_o |=> !exit_o);

    assert_never_both_R4: assert property (@(posedge clk_i) disable iff (rst_i)
        !(enter_o && exit_o));

    assert_enter_after_clear_R2: assert property (@(posedge clk_i) disable iff (rst_i)
        enter_o |-> ($past({a_i, b_i}) == 2'b00 && $past({a_i, b_i}, 2) == 2'b01));

    assert_exit_after_clear_R3: assert property (@(posedge clk_i) disable iff (rst_i)
        exit_o |-> ($past({a_i, b_i}) == 2'b00 && $past({a_i, b_i}, 2) == 2'b10));
endmodule

bind gate_dir_detector gdd_checker u_gdd_checker (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .a_i     (a_i),
    .b_i     (b_i),
    .enter_o (enter_o),
    .exit_o  (exit_o)
);

// File: tb/gate_dir_detector_test.sv
`timescale 1ns/1ps
module gate_dir_detector_test;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic a = 1'b0;
    logic b = 1'b0;
    logic enter_o, exit_o, led_a_o, led_b_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;
    string tag = "R8";

    // Reference model: need_clear, direction (0 none, 1 in, 2 out), step 1..3
    bit m_wait = 1'b1;
    int m_dir  = 0;
    int m_step = 0;
    bit e_in   = 1'b0;
    bit e_out  = 1'b0;
    int pulses_in  = 0;
    int pulses_out = 0;

    always #2.5 clk = ~clk;

    gate_dir_detector uut (
        .clk_i(clk), .rst_i(rst), .a_i(a), .b_i(b),
        .enter_o(enter_o), .exit_o(exit_o),
        .led_a_o(led_a_o), .led_b_o(led_b_o)
    );

    function automatic logic [1:0] pat(input int dir, input int idx);
        logic [1:0] p [3];
        if (dir == 1) begin p[0] = 2'b10; p[1] = 2'b11; p[2] = 2'b01; end
        else          begin p[0] = 2'b01; p[1] = 2'b11; p[2] = 2'b10; end
        return p[idx];
    endfunction

    task automatic model_edge(input logic [1:0] ab, input bit r);
        e_in = 1'b0; e_out = 1'b0;
        if (r) begin
            m_wait = 1'b1; m_dir = 0; m_step = 0;
        end else if (m_wait) begin
            if (ab == 2'b00) m_wait = 1'b0;
        end else if (m_dir == 0) begin
            if (ab == 2'b10)      begin m_dir = 1; m_step = 1; end
            else if (ab == 2'b01) begin m_dir = 2; m_step = 1; end
            else if (ab == 2'b11) m_wait = 1'b1;
        end else begin
            if (ab == pat(m_dir, m_step - 1)) begin
                // hold
            end else if (ab == 2'b00) begin
                if (m_step == 3) begin
                    if (m_dir == 1) e_in = 1'b1; else e_out = 1'b1;
                end
                m_dir = 0; m_step = 0;
            end else if (m_step < 3 && ab == pat(m_dir, m_step)) begin
                m_step++;
            end else begin
                m_wait = 1'b1; m_dir = 0; m_step = 0;
            end
        end
    endtask

    task automatic check(input string t, input string what, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %b expected %b at %0t", t, what, act, exp, $time);
        end
    endtask

    // One cycle: drive at negedge, check the indicators, then check strobes after the edge.
    task automatic cyc(input logic [1:0] ab);
        @(negedge clk);
        {a, b} = ab;
        #0.5;
        check("R1", "led_a", led_a_o, ab[1]);
        check("R1", "led_b", led_b_o, ab[0]);
        @(posedge clk);
        model_edge(ab, rst);
        #1;
        check(tag, "enter", enter_o, e_in);
        check(tag, "exit",  exit_o,  e_out);
        if (enter_o) pulses_in++;
        if (exit_o)  pulses_out++;
    endtask

    task automatic hold(input logic [1:0] ab, input int n);
        for (int i = 0; i < n; i++) cyc(ab);
    endtask

    task automatic count_is(input string t, input int got_in, input int got_out,
                            input int want_in, input int want_out);
        check(t, "enter count", logic'(got_in == want_in), 1'b1);
        check(t, "exit count",  logic'(got_out == want_out), 1'b1);
        if (got_in != want_in || got_out != want_out)
            $display("  counts %0d/%0d expected %0d/%0d", got_in, got_out, want_in, want_out);
    endtask

    task automatic seq(input logic [1:0] s0, input logic [1:0] s1, input logic [1:0] s2,
                       input logic [1:0] s3, input logic [1:0] s4, input int h);
        hold(s0, h); hold(s1, h); hold(s2, h); hold(s3, h); hold(s4, h);
    endtask

    initial begin : watchdog
        #500000;
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog expired: actual running expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin : stim
        int p0, q0;
        void'($urandom(32'h00C0FFEE));
        // R8: reset with the outer beam already blocked
        rst = 1'b1;
        hold(2'b10, 3);
        check("R8", "enter in reset", enter_o, 1'b0);
        check("R8", "exit in reset",  exit_o,  1'b0);
        rst = 1'b0;
        tag = "R8";
        p0 = pulses_in;
        hold(2'b11, 2); hold(2'b01, 2); hold(2'b00, 2);
        count_is("R8", pulses_in - p0, 0, 0, 0);

        // R2 basic entry, R3 basic exit
        tag = "R2"; p0 = pulses_in; q0 = pulses_out;
        seq(2'b00, 2'b10, 2'b11, 2'b01, 2'b00, 1); hold(2'b00, 2);
        count_is("R2", pulses_in - p0, pulses_out - q0, 1, 0);
        tag = "R3"; p0 = pulses_in; q0 = pulses_out;
        seq(2'b00, 2'b01, 2'b11, 2'b10, 2'b00, 1); hold(2'b00, 2);
        count_is("R3", pulses_in - p0, pulses_out - q0, 0, 1);

        // R5 long holds on every step; R4 pulse length checked per cycle
        tag = "R5"; p0 = pulses_in;
        seq(2'b00, 2'b10, 2'b11, 2'b01, 2'b00, 6);
        count_is("R5", pulses_in - p0, 0, 1, 0);
        tag = "R4"; q0 = pulses_out;
        seq(2'b00, 2'b01, 2'b11, 2'b10, 2'b00, 4);
        count_is("R4", 0, pulses_out - q0, 0, 1);

        // R6 early clear, then immediate new car
        tag = "R6"; p0 = pulses_in; q0 = pulses_out;
        hold(2'b00, 1); hold(2'b10, 2); hold(2'b00, 1);
        hold(2'b10, 1); hold(2'b11, 1); hold(2'b01, 1); hold(2'b00, 2);
        hold(2'b01, 1); hold(2'b11, 1); hold(2'b00, 2);
        count_is("R6", pulses_in - p0, pulses_out - q0, 1, 0);

        // R7 out-of-order: 10 then 01, 11 from armed, backward step
        tag = "R7"; p0 = pulses_in; q0 = pulses_out;
        hold(2'b00, 1); hold(2'b10, 1); hold(2'b01, 1); hold(2'b11, 1); hold(2'b10, 1); hold(2'b00, 1);
        hold(2'b11, 1); hold(2'b01, 1); hold(2'b00, 1);
        hold(2'b10, 1); hold(2'b11, 1); hold(2'b10, 1); hold(2'b11, 1); hold(2'b01, 1); hold(2'b00, 2);
        count_is("R7", pulses_in - p0, pulses_out - q0, 0, 0);

        // R9 back-to-back cars share one 00 sample
        tag = "R9"; p0 = pulses_in; q0 = pulses_out;
        hold(2'b00, 1);
        hold(2'b10, 1); hold(2'b11, 1); hold(2'b01, 1); hold(2'b00, 1);
        hold(2'b01, 1); hold(2'b11, 1); hold(2'b10, 1); hold(2'b00, 1);
        hold(2'b10, 1); hold(2'b11, 1); hold(2'b01, 1); hold(2'b00, 2);
        count_is("R9", pulses_in - p0, pulses_out - q0, 2, 1);

        // R8 reset in the middle of a pass
        tag = "R8";
        hold(2'b10, 1); hold(2'b11, 1);
        rst = 1'b1; hold(2'b01, 1); rst = 1'b0;
        hold(2'b00, 1);
        check("R8", "enter after mid reset", enter_o, 1'b0);

        // Random mix of whole passes, aborts and noise, per-cycle model compare
        tag = "R2";
        for (int k = 0; k < 400; k++) begin
            int kind = int'($urandom_range(0, 3));
            int h = int'($urandom_range(1, 3));
            case (kind)
                0: begin tag = "R2"; seq(2'b00, 2'b10, 2'b11, 2'b01, 2'b00, h); end
                1: begin tag = "R3"; seq(2'b00, 2'b01, 2'b11, 2'b10, 2'b00, h); end
                2: begin tag = "R6"; hold(2'b10, h); hold(2'b00, h); end
                default: begin
                    tag = "R7";
                    for (int j = 0; j < 4; j++) hold(2'($urandom_range(0, 3)), h);
                end
            endcase
        end
        hold(2'b00, 3);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule